// File: doc/BRIEF.md
# PPU Mode Timing Monitor

This block sits beside a pixel-processing unit and observes, once per dot clock, the two-bit display mode and the current line number. It does not generate any timing itself. From what it sees it builds a bank of statistics: how often each of the four modes was entered, how many dot cycles were spent in each, and the lowest and highest line numbers that appeared. The counters are exposed as plain output buses so that a surrounding register file can read them.

Two timing alarms are derived from the same samples. A run of pixel transfer longer than one full 456-dot scanline is a stall; it is counted at most once per frame, with a per-frame flag that the frame-start pulse re-arms. A dominance flag reports when pixel-transfer cycles make up more than 60 % of all accumulated cycles, evaluated as an integer ratio with no divider. A sticky error bit catches any visible-area mode reported on a line number that belongs to vertical blanking.

A synchronous clear input restarts the whole bank; the cycle on which clear is high is not sampled.

Top module: `ppu_mode_monitor`

## Requirements
- R1: Mode encoding is 0 = horizontal blank, 1 = vertical blank, 2 = object search, 3 = pixel transfer. `entry_cnt_o[m]` rises by one on each sampled cycle whose mode is m and differs from the mode of the previous sampled cycle; the first sampled cycle after reset or clear never counts as an entry.
- R2: Every sampled cycle adds exactly one to `cycle_cnt_o[m]` for the mode m present on that cycle; no other accumulator moves.
- R3: `line_min_o` and `line_max_o` hold the smallest and largest `line_i` value seen over all sampled cycles since the last reset or clear.
- R4: A stall is the 457th and every later consecutive sampled cycle in mode 3; any other mode restarts the run. The first stall cycle of a frame increments `stuck_frames_o` by one and sets `stuck_flag_o`; further stall cycles in the same frame change neither.
- R5: A cycle with `frame_start_i` high clears `stuck_flag_o`; if that same cycle is itself a stall cycle it counts as the first stall of the new frame (counter +1, flag stays set).
- R6: `dominant_o` is high exactly when 5 × `cycle_cnt_o[3]` is strictly greater than 3 × (sum of all four cycle counters); it is low when all counters are zero.
- R7: `range_err_o` becomes 1 after any sampled cycle where the mode is not 1 and `line_i` is 144 or more, and stays 1 until reset or clear.
- R8: Reset, and a cycle with `clear_i` high, set all entry, cycle and stall counters to zero, `line_min_o` to 0xFF, `line_max_o` to 0x00, all flags to 0, and restart the mode-3 run; that cycle is not sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Dot clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous restart of all statistics |
| frame_start_i | input | 1 | One-cycle pulse at the start of each frame |
| mode_i | input | 2 | Observed display mode |
| line_i | input | 8 | Observed line number |
| entry_cnt_o | output | 4×32 | Mode entry counters, index = mode |
| cycle_cnt_o | output | 4×32 | Per-mode cycle accumulators, index = mode |
| line_min_o | output | 8 | Lowest line number seen |
| line_max_o | output | 8 | Highest line number seen |
| stuck_frames_o | output | 32 | Frames with a pixel-transfer stall |
| stuck_flag_o | output | 1 | Stall already seen in the current frame |
| dominant_o | output | 1 | Pixel transfer exceeds 60 % of cycles |
| range_err_o | output | 1 | Sticky mode/line mismatch error |

## Verification
Every statistic and flag is registered at the rising edge that samples the inputs, so each result is due one edge after the cycle that carries its stimulus; the dominance flag is a comparison of those registered counters and is therefore due at the same moment. The bench changes inputs just after a falling edge and reads outputs at the next falling edge, half a period after the sampling edge, so each check sees exactly the cycles driven so far. The stall threshold is probed by holding mode 3 for 456 cycles and checking, then adding one more cycle and checking again, and the frame-start priority is probed with the pulse on a stall cycle and on a non-stall cycle.

// File: rtl/ppu_mon_pkg.sv
package ppu_mon_pkg;

    localparam int NUM_MODES = 4;
    localparam int MODE_W    = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_HBLANK = 2'd0,
        MODE_VBLANK = 2'd1,
        MODE_SEARCH = 2'd2,
        MODE_XFER   = 2'd3
    } ppu_mode_e;

endpackage

// File: rtl/ppu_mon_counters.sv
module ppu_mon_counters
    import ppu_mon_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                                 clk_i,
    input  logic                                 rst_ni,
    input  logic                                 clear_i,
    input  logic [MODE_W-1:0]                    mode_i,
    output logic [NUM_MODES-1:0][CNT_W-1:0]      entry_cnt_o,
    output logic [NUM_MODES-1:0][CNT_W-1:0]      cycle_cnt_o
);

    typedef struct packed {
        logic                               valid;
        ppu_mode_e                          prev;
        logic [NUM_MODES-1:0][CNT_W-1:0]    entry;
        logic [NUM_MODES-1:0][CNT_W-1:0]    cyc;
    } cnt_state_t;

    cnt_state_t state_d, state_q;

    // one-hot decode of the observed mode
    logic [NUM_MODES-1:0] hit;
    logic                 changed;

    for (genvar g = 0; g < NUM_MODES; g++) begin : g_hit
        assign hit[g] = (mode_i == MODE_W'(g));
    end

    assign changed = state_q.valid && (state_q.prev != ppu_mode_e'(mode_i));

    always_comb begin
        state_d = state_q;
        if (clear_i) begin
            state_d = '0;
        end else begin
            state_d.valid = 1'b1;
            state_d.prev  = ppu_mode_e'(mode_i);
            for (int m = 0; m < NUM_MODES; m++) begin
                if (hit[m]) begin
                    state_d.cyc[m] = state_q.cyc[m] + CNT_W'(1);
                    if (changed) begin
                        state_d.entry[m] = state_q.entry[m] + CNT_W'(1);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign entry_cnt_o = state_q.entry;
    assign cycle_cnt_o = state_q.cyc;

endmodule

// File: rtl/ppu_mon_line.sv
module ppu_mon_line
    import ppu_mon_pkg::*;
#(
    parameter int LINE_W       = 8,
    parameter int VBLANK_FIRST = 144
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                clear_i,
    input  logic [MODE_W-1:0]   mode_i,
    input  logic [LINE_W-1:0]   line_i,
    output logic [LINE_W-1:0]   line_min_o,
    output logic [LINE_W-1:0]   line_max_o,
    output logic                range_err_o
);

    typedef struct packed {
        logic [LINE_W-1:0] lo;
        logic [LINE_W-1:0] hi;
        logic              err;
    } line_state_t;

    localparam line_state_t LINE_INIT = '{lo: '1, hi: '0, err: 1'b0};

    line_state_t state_d, state_q;
    logic        in_blank_lines;
    logic        bad_combo;

    assign in_blank_lines = (line_i >= LINE_W'(VBLANK_FIRST));
    assign bad_combo      = in_blank_lines && (ppu_mode_e'(mode_i) != MODE_VBLANK);

    always_comb begin
        state_d = state_q;
        if (clear_i) begin
            state_d = LINE_INIT;
        end else begin
            if (line_i < state_q.lo) state_d.lo = line_i;
            if (line_i > state_q.hi) state_d.hi = line_i;
            state_d.err = state_q.err | bad_combo;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= LINE_INIT;
        end else begin
            state_q <= state_d;
        end
    end

    assign line_min_o  = state_q.lo;
    assign line_max_o  = state_q.hi;
    assign range_err_o = state_q.err;

endmodule

// File: rtl/ppu_mon_stall.sv
module ppu_mon_stall
    import ppu_mon_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int LINE_DOTS = 456
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               clear_i,
    input  logic               frame_start_i,
    input  logic [MODE_W-1:0]  mode_i,
    output logic [CNT_W-1:0]   stuck_frames_o,
    output logic               stuck_flag_o
);

    localparam int RUN_W = $clog2(LINE_DOTS + 1);
    localparam logic [RUN_W-1:0] RUN_LIMIT = RUN_W'(LINE_DOTS);

    typedef struct packed {
        logic [RUN_W-1:0] run;
        logic             flag;
        logic [CNT_W-1:0] frames;
    } stall_state_t;

    stall_state_t state_d, state_q;
    logic         in_xfer;
    logic         over_line;
    logic         flag_armed;

    assign in_xfer    = (ppu_mode_e'(mode_i) == MODE_XFER);
    // run holds the mode-3 cycles already seen; this cycle is run+1
    assign over_line  = in_xfer && (state_q.run >= RUN_LIMIT);
    // frame start re-arms the detector before this cycle is judged
    assign flag_armed = frame_start_i ? 1'b0 : state_q.flag;

    always_comb begin
        state_d = state_q;
        if (clear_i) begin
            state_d = '0;
        end else begin
            if (!in_xfer) begin
                state_d.run = '0;
            end else if (state_q.run != RUN_LIMIT) begin
                state_d.run = state_q.run + RUN_W'(1);
            end
            state_d.flag = flag_armed;
            if (over_line && !flag_armed) begin
                state_d.flag   = 1'b1;
                state_d.frames = state_q.frames + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign stuck_frames_o = state_q.frames;
    assign stuck_flag_o   = state_q.flag;

endmodule

// File: rtl/ppu_mon_ratio.sv
module ppu_mon_ratio
    import ppu_mon_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int RATIO_NUM = 3,
    parameter int RATIO_DEN = 5,
    parameter int WATCH     = 3
) (
    input  logic [NUM_MODES-1:0][CNT_W-1:0] cycle_cnt_i,
    output logic                            dominant_o
);

    localparam int SUM_W  = CNT_W + $clog2(NUM_MODES);
    localparam int MAX_K  = (RATIO_NUM > RATIO_DEN) ? RATIO_NUM : RATIO_DEN;
    localparam int MULT_W = $clog2(MAX_K + 1);
    localparam int PROD_W = SUM_W + MULT_W;

    logic [SUM_W-1:0]  total;
    logic [PROD_W-1:0] lhs;
    logic [PROD_W-1:0] rhs;

    always_comb begin
        total = '0;
        for (int m = 0; m < NUM_MODES; m++) begin
            total = total + SUM_W'(cycle_cnt_i[m]);
        end
    end

    // part / total > NUM / DEN  <=>  part * DEN > total * NUM
    assign lhs        = PROD_W'(cycle_cnt_i[WATCH]) * PROD_W'(RATIO_DEN);
    assign rhs        = PROD_W'(total) * PROD_W'(RATIO_NUM);
    assign dominant_o = (lhs > rhs);

endmodule

// File: rtl/ppu_mode_monitor.sv
module ppu_mode_monitor
    import ppu_mon_pkg::*;
#(
    parameter int CNT_W        = 32,
    parameter int LINE_W       = 8,
    parameter int LINE_DOTS    = 456,
    parameter int VBLANK_FIRST = 144,
    parameter int RATIO_NUM    = 3,
    parameter int RATIO_DEN    = 5
) (
    input  logic                              clk_i,
    input  logic                              rst_ni,
    input  logic                              clear_i,
    input  logic                              frame_start_i,
    input  logic [1:0]                        mode_i,
    input  logic [LINE_W-1:0]                 line_i,
    output logic [3:0][CNT_W-1:0]             entry_cnt_o,
    output logic [3:0][CNT_W-1:0]             cycle_cnt_o,
    output logic [LINE_W-1:0]                 line_min_o,
    output logic [LINE_W-1:0]                 line_max_o,
    output logic [CNT_W-1:0]                  stuck_frames_o,
    output logic                              stuck_flag_o,
    output logic                              dominant_o,
    output logic                              range_err_o
);

    ppu_mon_counters #(
        .CNT_W (CNT_W)
    ) u_counters (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .clear_i     (clear_i),
        .mode_i      (mode_i),
        .entry_cnt_o (entry_cnt_o),
        .cycle_cnt_o (cycle_cnt_o)
    );

    ppu_mon_line #(
        .LINE_W       (LINE_W),
        .VBLANK_FIRST (VBLANK_FIRST)
    ) u_line (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .clear_i     (clear_i),
        .mode_i      (mode_i),
        .line_i      (line_i),
        .line_min_o  (line_min_o),
        .line_max_o  (line_max_o),
        .range_err_o (range_err_o)
    );

    ppu_mon_stall #(
        .CNT_W     (CNT_W),
        .LINE_DOTS (LINE_DOTS)
    ) u_stall (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .clear_i        (clear_i),
        .frame_start_i  (frame_start_i),
        .mode_i         (mode_i),
        .stuck_frames_o (stuck_frames_o),
        .stuck_flag_o   (stuck_flag_o)
    );

    ppu_mon_ratio #(
        .CNT_W     (CNT_W),
        .RATIO_NUM (RATIO_NUM),
        .RATIO_DEN (RATIO_DEN),
        .WATCH     (int'(MODE_XFER))
    ) u_ratio (
        .cycle_cnt_i (cycle_cnt_o),
        .dominant_o  (dominant_o)
    );

endmodule

// File: rtl/ppu_mode_monitor_chk.sv
module ppu_mode_monitor_chk #(
    parameter int CNT_W        = 32,
    parameter int LINE_W       = 8,
    parameter int VBLANK_FIRST = 144
) (
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic                  clear_i,
    input logic                  frame_start_i,
    input logic [1:0]            mode_i,
    input logic [LINE_W-1:0]     line_i,
    input logic [3:0][CNT_W-1:0] entry_cnt_o,
    input logic [3:0][CNT_W-1:0] cycle_cnt_o,
    input logic [LINE_W-1:0]     line_min_o,
    input logic [LINE_W-1:0]     line_max_o,
    input logic [CNT_W-1:0]      stuck_frames_o,
    input logic                  stuck_flag_o,
    input logic                  dominant_o,
    input logic                  range_err_o
);

    logic [CNT_W+1:0] total_w;

    always_comb begin
        total_w = '0;
        for (int m = 0; m < 4; m++) total_w = total_w + (CNT_W+2)'(cycle_cnt_o[m]);
    end

    for (genvar g = 0; g < 4; g++) begin : g_mode
        p_entry_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !clear_i |=> (entry_cnt_o[g] == $past(entry_cnt_o[g]) ||
                          entry_cnt_o[g] == $past(entry_cnt_o[g]) + CNT_W'(1)));
    end

    p_cycle_sum_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clear_i |=> total_w == $past(total_w) + (CNT_W+2)'(1));

    p_line_bounds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clear_i |=> (line_min_o <= $past(line_i) && line_max_o >= $past(line_i)));

    p_stall_once_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clear_i && stuck_flag_o && !frame_start_i) |=> $stable(stuck_frames_o));

    p_frame_rearm_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clear_i && frame_start_i) |=>
            (!stuck_flag_o || stuck_frames_o == $past(stuck_frames_o) + CNT_W'(1)));

    p_dom_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> !dominant_o);

    p_range_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clear_i && mode_i != 2'd1 && line_i >= LINE_W'(VBLANK_FIRST)) |=> range_err_o);

    p_range_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clear_i && range_err_o) |=> range_err_o);

    p_clear_state_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> (line_min_o == '1 && line_max_o == '0 && stuck_frames_o == '0 &&
                     !stuck_flag_o && !range_err_o && total_w == '0));

endmodule

bind ppu_mode_monitor ppu_mode_monitor_chk #(
    .CNT_W        (CNT_W),
    .LINE_W       (LINE_W),
    .VBLANK_FIRST (VBLANK_FIRST)
) chk_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .clear_i        (clear_i),
    .frame_start_i  (frame_start_i),
    .mode_i         (mode_i),
    .line_i         (line_i),
    .entry_cnt_o    (entry_cnt_o),
    .cycle_cnt_o    (cycle_cnt_o),
    .line_min_o     (line_min_o),
    .line_max_o     (line_max_o),
    .stuck_frames_o (stuck_frames_o),
    .stuck_flag_o   (stuck_flag_o),
    .dominant_o     (dominant_o),
    .range_err_o    (range_err_o)
);

// File: tb/ppu_mode_monitor_tb_top.sv
module ppu_mode_monitor_tb_top;

    logic             clk_i = 1'b0;
    logic             rst_ni = 1'b0;
    logic             clear_i = 1'b0;
    logic             frame_start_i = 1'b0;
    logic [1:0]       mode_i = 2'd0;
    logic [7:0]       line_i = 8'd0;
    logic [3:0][31:0] entry_cnt_o;
    logic [3:0][31:0] cycle_cnt_o;
    logic [7:0]       line_min_o;
    logic [7:0]       line_max_o;
    logic [31:0]      stuck_frames_o;
    logic             stuck_flag_o;
    logic             dominant_o;
    logic             range_err_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk_i = ~clk_i;

    ppu_mode_monitor dut_i (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .clear_i        (clear_i),
        .frame_start_i  (frame_start_i),
        .mode_i         (mode_i),
        .line_i         (line_i),
        .entry_cnt_o    (entry_cnt_o),
        .cycle_cnt_o    (cycle_cnt_o),
        .line_min_o     (line_min_o),
        .line_max_o     (line_max_o),
        .stuck_frames_o (stuck_frames_o),
        .stuck_flag_o   (stuck_flag_o),
        .dominant_o     (dominant_o),
        .range_err_o    (range_err_o)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive n sampled cycles; returns at the falling edge after the last sample
    task automatic run_cycles(input logic [1:0] m, input logic [7:0] l, input int n);
        for (int i = 0; i < n; i++) begin
            mode_i = m;
            line_i = l;
            @(negedge clk_i);
        end
    endtask

    task automatic do_clear();
        clear_i = 1'b1;
        @(negedge clk_i);
        clear_i = 1'b0;
    endtask

    task automatic frame_pulse(input logic [1:0] m, input logic [7:0] l);
        frame_start_i = 1'b1;
        mode_i = m;
        line_i = l;
        @(negedge clk_i);
        frame_start_i = 1'b0;
    endtask

    task automatic check_idle(input string req);
        for (int m = 0; m < 4; m++) begin
            check({req, " entry"}, entry_cnt_o[m], 0);
            check({req, " cycles"}, cycle_cnt_o[m], 0);
        end
        check({req, " min"}, line_min_o, 255);
        check({req, " max"}, line_max_o, 0);
        check({req, " stall count"}, stuck_frames_o, 0);
        check({req, " stall flag"}, stuck_flag_o, 0);
        check({req, " dominant"}, dominant_o, 0);
        check({req, " range"}, range_err_o, 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk_i);
        check_idle("R8 reset");
        rst_ni = 1'b1;
    endtask

    task automatic t_nominal_lines();
        do_clear();
        for (int l = 0; l < 3; l++) begin
            run_cycles(2'd2, 8'(l), 80);
            run_cycles(2'd3, 8'(l), 172);
            run_cycles(2'd0, 8'(l), 204);
        end
        check("R1 entries mode2", entry_cnt_o[2], 2);
        check("R1 entries mode3", entry_cnt_o[3], 3);
        check("R1 entries mode0", entry_cnt_o[0], 3);
        check("R1 entries mode1", entry_cnt_o[1], 0);
        check("R2 cycles mode2", cycle_cnt_o[2], 240);
        check("R2 cycles mode3", cycle_cnt_o[3], 516);
        check("R2 cycles mode0", cycle_cnt_o[0], 612);
        check("R2 cycles mode1", cycle_cnt_o[1], 0);
        check("R3 min", line_min_o, 0);
        check("R3 max", line_max_o, 2);
        check("R6 not dominant", dominant_o, 0);
        check("R4 no stall", stuck_frames_o, 0);
        run_cycles(2'd1, 8'd144, 456);
        check("R1 entries mode1", entry_cnt_o[1], 1);
        check("R2 cycles mode1", cycle_cnt_o[1], 456);
        check("R3 max vblank", line_max_o, 144);
        check("R7 vblank legal", range_err_o, 0);
    endtask

    task automatic t_first_after_clear();
        run_cycles(2'd0, 8'd0, 5);
        do_clear();
        run_cycles(2'd3, 8'd0, 2);
        check("R1 first sample not entry", entry_cnt_o[3], 0);
        check("R2 cycles after clear", cycle_cnt_o[3], 2);
        run_cycles(2'd1, 8'd150, 1);
        check("R1 change counts", entry_cnt_o[1], 1);
    endtask

    task automatic t_dominance();
        do_clear();
        check("R6 zero totals", dominant_o, 0);
        run_cycles(2'd3, 8'd0, 3);
        check("R6 15>9", dominant_o, 1);
        run_cycles(2'd0, 8'd0, 2);
        check("R6 equal 15=15", dominant_o, 0);
        run_cycles(2'd3, 8'd0, 1);
        check("R6 20>18", dominant_o, 1);
    endtask

    task automatic t_stall();
        do_clear();
        frame_pulse(2'd0, 8'd10);
        run_cycles(2'd3, 8'd10, 456);
        check("R4 456 cycles no stall", stuck_frames_o, 0);
        check("R4 456 cycles flag", stuck_flag_o, 0);
        run_cycles(2'd3, 8'd10, 1);
        check("R4 457th cycle stall", stuck_frames_o, 1);
        check("R4 flag set", stuck_flag_o, 1);
        run_cycles(2'd3, 8'd10, 300);
        check("R4 once per frame", stuck_frames_o, 1);
        frame_pulse(2'd3, 8'd10);
        check("R5 frame start on stall", stuck_frames_o, 2);
        check("R5 flag kept", stuck_flag_o, 1);
        frame_pulse(2'd0, 8'd10);
        check("R5 frame start rearms", stuck_flag_o, 0);
        check("R5 count held", stuck_frames_o, 2);
        run_cycles(2'd3, 8'd10, 400);
        run_cycles(2'd0, 8'd10, 1);
        run_cycles(2'd3, 8'd10, 400);
        check("R4 broken run", stuck_frames_o, 2);
        check("R4 broken run flag", stuck_flag_o, 0);
        do_clear();
        run_cycles(2'd3, 8'd10, 100);
        check("R8 clear restarts run", stuck_frames_o, 0);
    endtask

    task automatic t_lines();
        do_clear();
        run_cycles(2'd2, 8'd10, 1);
        check("R3 min first", line_min_o, 10);
        check("R3 max first", line_max_o, 10);
        run_cycles(2'd0, 8'd5, 1);
        check("R3 min lower", line_min_o, 5);
        run_cycles(2'd0, 8'd143, 1);
        check("R7 line 143 ok", range_err_o, 0);
        run_cycles(2'd1, 8'd150, 1);
        check("R7 vblank ok", range_err_o, 0);
        check("R3 max", line_max_o, 150);
        run_cycles(2'd0, 8'd144, 1);
        check("R7 error set", range_err_o, 1);
        run_cycles(2'd2, 8'd0, 1);
        check("R7 sticky", range_err_o, 1);
        check("R3 min zero", line_min_o, 0);
        do_clear();
        check_idle("R8 clear");
    endtask

    initial begin
        repeat (200000) @(posedge clk_i);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        t_nominal_lines();
        t_first_after_clear();
        t_dominance();
        t_stall();
        t_lines();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule